// File: doc/BRIEF.md
# Way-Lockable Set-Associative Data Cache

This block is a write-back data cache for a 32-bit processor. It is four-way set-associative, holds 4 KB, and keeps 32 lines of eight 32-bit words in each way. The core issues one word read or write at a time, with byte enables. It holds the request until the cache raises a one-cycle ready. Hits answer in the cycle the request is presented. A miss makes the cache fetch the whole line over a burst memory port. If the line chosen for replacement holds modified data, that line is first written back in a burst of its own.

Software can pin the contents of any way through a 4-bit lock mask. A locked way still serves hits, and write hits still modify it. The replacement logic never picks a locked way. When every way is locked, misses go straight to memory as single-word transfers. The cache takes part only while both its enable input and the memory-protection enable input are high. Otherwise every access becomes a single-word memory transfer.

Top module: `lockable_dcache`

## Requirements
- R1: While `cfg_enable` or `mpu_enable` is low, every core access produces exactly one single-word memory transfer (`mem_burst` low) at `req_addr`, using the request's write flag, data and byte enables. Read data is returned from memory in the cycle of `mem_ack`, and no line is filled.
- R2: Address bits [4:0] select the byte within a line and bits [4:2] the word. Bits [9:5] pick the set and bits [31:10] form the tag. Once a line is present, reads of any of its eight words return cached data without memory traffic.
- R3: A read or write miss with a clean or empty victim performs one eight-beat read burst (`mem_burst` high, `mem_we` low). The beats run in word order from the line base. The request is answered only after the last beat.
- R4: A write hit updates only the bytes whose `req_be` bit is set, causes no memory traffic, and leaves the memory copy untouched until eviction.
- R5: When the victim line is modified, an eight-beat write burst of that line, in word order from its base, completes before the refill burst begins. Afterwards memory holds the modified data.
- R6: The victim is the lowest-numbered invalid unlocked way. If there is none, it is the first unlocked way found by counting upward from a rotating pointer. After each fill the pointer moves to one past the filled way.
- R7: A way whose `lock_mask` bit is set is never chosen as victim, so its lines survive any amount of conflicting traffic.
- R8: With all four ways locked, a miss is served as a single-word memory transfer and allocates nothing, so a repeated miss to the same address goes to memory again.
- R9: Read and write hits in locked ways are served from the cache like any other hit.
- R10: Reset clears every valid and dirty bit and sets the rotating pointer to way 0. During reset `req_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Cache enable bit |
| mpu_enable | input | 1 | Memory-protection enable; cache acts only when both are high |
| lock_mask | input | 4 | One lock bit per way |
| req_valid | input | 1 | Core request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_ready | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, valid while `req_ready` is high |
| mem_req | output | 1 | Memory beat requested; held with stable address until `mem_ack` |
| mem_we | output | 1 | Beat is a write |
| mem_burst | output | 1 | Beat belongs to an eight-word line transfer |
| mem_addr | output | 32 | Address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_be | output | 4 | Byte enables of the current beat |
| mem_ack | input | 1 | Memory accepts or returns the current beat |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench builds the cache with its default parameters: four ways, 32 sets, eight-word lines and 32-bit data and address. With these values one way spans 1 KB, so a 16 KB backing window offers sixteen distinct tags per set. That is enough to overflow a set many times over, to make the rotating pointer wrap, and to pit heavy conflict traffic against locked ways. Memory acknowledges beats at random so that every burst sees wait states, and the order of writeback and refill beats is compared address by address.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WBACK  = 2'd1,
      ST_FILL   = 2'd2,
      ST_BYPASS = 2'd3
   } dc_state_e;
endpackage

// File: rtl/dc_victim.sv
`timescale 1ns/1ps
module dc_victim #(
   parameter int WAYS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [WAYS-1:0]         valid_i,
   input  logic [WAYS-1:0]         lock_i,
   input  logic                    advance_i,
   input  logic [$clog2(WAYS)-1:0] filled_way_i,
   output logic [$clog2(WAYS)-1:0] victim_o,
   output logic                    none_o
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAY_W-1:0] ptr_q;
   logic [WAY_W-1:0] cand;
   logic             found;

   always_comb begin
      victim_o = '0;
      found    = 1'b0;
      cand     = '0;
      for (int k = 0; k < WAYS; k++) begin
         if (!found && !lock_i[k] && !valid_i[k]) begin
            victim_o = WAY_W'(k);
            found    = 1'b1;
         end
      end
      for (int k = 0; k < WAYS; k++) begin
         cand = ptr_q + WAY_W'(k);
         if (!found && !lock_i[cand]) begin
            victim_o = cand;
            found    = 1'b1;
         end
      end
      none_o = &lock_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q <= '0;
      else if (advance_i) ptr_q <= filled_way_i + WAY_W'(1);
   end
endmodule

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
module dc_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 32,
   parameter int TAG_W = 22
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [$clog2(SETS)-1:0]         idx_i,
   output logic [WAYS-1:0][TAG_W-1:0]      tag_o,
   output logic [WAYS-1:0]                 valid_o,
   output logic [WAYS-1:0]                 dirty_o,
   input  logic                            alloc_i,
   input  logic [$clog2(WAYS)-1:0]         alloc_way_i,
   input  logic [TAG_W-1:0]                alloc_tag_i,
   input  logic                            mark_i,
   input  logic [$clog2(WAYS)-1:0]         mark_way_i
);
   localparam int WAY_W = $clog2(WAYS);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tags [SETS];
      logic [SETS-1:0]  vld;
      logic [SETS-1:0]  drt;
      logic             alloc_here;
      logic             mark_here;

      assign alloc_here = alloc_i && (alloc_way_i == WAY_W'(w));
      assign mark_here  = mark_i  && (mark_way_i  == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld <= '0;
            drt <= '0;
         end else if (alloc_here) begin
            vld[idx_i] <= 1'b1;
            drt[idx_i] <= 1'b0;
         end else if (mark_here) begin
            drt[idx_i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (alloc_here) tags[idx_i] <= alloc_tag_i;
      end

      assign tag_o[w]   = tags[idx_i];
      assign valid_o[w] = vld[idx_i];
      assign dirty_o[w] = drt[idx_i];
   end
endmodule

// File: rtl/dc_data_store.sv
`timescale 1ns/1ps
module dc_data_store #(
   parameter int ADDR_W = 10,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DW-1:0]     rdata,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DW/8-1:0]   wbe,
   input  logic [DW-1:0]     wdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DW-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < DW/8; b++) begin
            if (wbe[b]) words[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
         end
      end
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/lockable_dcache.sv
`timescale 1ns/1ps
module lockable_dcache
   import dc_pkg::*;
#(
   parameter int WAYS       = 4,
   parameter int SETS       = 32,
   parameter int LINE_WORDS = 8,
   parameter int AW         = 32,
   parameter int DW         = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              mpu_enable,
   input  logic [WAYS-1:0]   lock_mask,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [DW/8-1:0]   req_be,
   output logic              req_ready,
   output logic [DW-1:0]     rsp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_burst,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW/8-1:0]   mem_be,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata
);
   localparam int BE_W   = DW / 8;
   localparam int BOFF   = $clog2(BE_W);
   localparam int WSEL_W = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = AW - WSEL_W - BOFF - IDX_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int DA_W   = WAY_W + IDX_W + WSEL_W;

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (DW < 16 || (DW % 8) != 0 || (BE_W & (BE_W - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   dc_state_e          state_q;
   logic [WSEL_W-1:0]  beat_q;
   logic [WAY_W-1:0]   vic_q;
   logic [TAG_W-1:0]   vic_tag_q;

   logic [IDX_W-1:0]   req_idx;
   logic [TAG_W-1:0]   req_tag;
   logic [WSEL_W-1:0]  req_wsel;
   logic [WAYS-1:0][TAG_W-1:0] tag_rd;
   logic [WAYS-1:0]    valid_rd;
   logic [WAYS-1:0]    dirty_rd;
   logic [WAYS-1:0]    hit_vec;
   logic               hit;
   logic [WAY_W-1:0]   hit_way;
   logic [WAY_W-1:0]   victim;
   logic               none_free;
   logic               active;
   logic               miss_start;
   logic               last_beat;
   logic               alloc;
   logic               mark;
   logic [DA_W-1:0]    da_raddr;
   logic [DA_W-1:0]    da_waddr;
   logic [DW-1:0]      da_rdata;
   logic [DW-1:0]      da_wdata;
   logic [BE_W-1:0]    da_wbe;
   logic               da_we;

   assign req_wsel = req_addr[BOFF +: WSEL_W];
   assign req_idx  = req_addr[BOFF + WSEL_W +: IDX_W];
   assign req_tag  = req_addr[AW-1 -: TAG_W];
   assign active   = cfg_enable && mpu_enable;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid_rd[w] && (tag_rd[w] == req_tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end
   assign hit = |hit_vec;

   assign miss_start = (state_q == ST_IDLE) && req_valid && active && !hit && !none_free;
   assign last_beat  = &beat_q;
   assign alloc      = (state_q == ST_FILL) && mem_ack && last_beat;
   assign mark       = (state_q == ST_IDLE) && req_valid && active && hit && req_write;

   dc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx_i(req_idx),
      .tag_o(tag_rd), .valid_o(valid_rd), .dirty_o(dirty_rd),
      .alloc_i(alloc), .alloc_way_i(vic_q), .alloc_tag_i(req_tag),
      .mark_i(mark), .mark_way_i(hit_way)
   );

   dc_victim #(.WAYS(WAYS)) u_victim (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_rd), .lock_i(lock_mask),
      .advance_i(alloc), .filled_way_i(vic_q),
      .victim_o(victim), .none_o(none_free)
   );

   assign da_raddr = (state_q == ST_WBACK) ? {vic_q, req_idx, beat_q} : {hit_way, req_idx, req_wsel};
   assign da_we    = ((state_q == ST_FILL) && mem_ack) || mark;
   assign da_waddr = (state_q == ST_FILL) ? {vic_q, req_idx, beat_q} : {hit_way, req_idx, req_wsel};
   assign da_wbe   = (state_q == ST_FILL) ? {BE_W{1'b1}} : req_be;
   assign da_wdata = (state_q == ST_FILL) ? mem_rdata : req_wdata;

   dc_data_store #(.ADDR_W(DA_W), .DW(DW)) u_data (
      .clk(clk), .raddr(da_raddr), .rdata(da_rdata),
      .we(da_we), .waddr(da_waddr), .wbe(da_wbe), .wdata(da_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         beat_q    <= '0;
         vic_q     <= '0;
         vic_tag_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!active || (!hit && none_free)) begin
                     state_q <= ST_BYPASS;
                  end else if (!hit) begin
                     vic_q     <= victim;
                     vic_tag_q <= tag_rd[victim];
                     beat_q    <= '0;
                     state_q   <= (valid_rd[victim] && dirty_rd[victim]) ? ST_WBACK : ST_FILL;
                  end
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  beat_q <= beat_q + WSEL_W'(1);
                  if (last_beat) state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + WSEL_W'(1);
                  if (last_beat) state_q <= ST_IDLE;
               end
            end
            ST_BYPASS: begin
               if (mem_ack) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state_q != ST_IDLE);
      mem_burst = (state_q == ST_WBACK) || (state_q == ST_FILL);
      mem_we    = (state_q == ST_WBACK) || ((state_q == ST_BYPASS) && req_write);
      mem_be    = (state_q == ST_BYPASS) ? req_be : {BE_W{1'b1}};
      mem_wdata = (state_q == ST_WBACK) ? da_rdata : req_wdata;
      unique case (state_q)
         ST_WBACK: mem_addr = {vic_tag_q, req_idx, beat_q, {BOFF{1'b0}}};
         ST_FILL:  mem_addr = {req_tag,   req_idx, beat_q, {BOFF{1'b0}}};
         default:  mem_addr = req_addr;
      endcase
      req_ready = ((state_q == ST_IDLE) && req_valid && active && hit) ||
                  ((state_q == ST_BYPASS) && mem_ack);
      rsp_rdata = (state_q == ST_BYPASS) ? mem_rdata : da_rdata;
   end
endmodule

// File: rtl/dc_checker.sv
`timescale 1ns/1ps
module dc_checker #(
   parameter int WAYS = 4,
   parameter int AW   = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_enable,
   input logic                    mpu_enable,
   input logic [WAYS-1:0]         lock_mask,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic                    mem_req,
   input logic                    mem_we,
   input logic                    mem_burst,
   input logic [AW-1:0]           mem_addr,
   input logic                    mem_ack,
   input logic                    miss_start,
   input logic [$clog2(WAYS)-1:0] victim
);
   // R1
   burst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst && !$past(mem_req)) |-> $past(cfg_enable && mpu_enable));

   // R3
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R5
   wback_ends_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst && !mem_we && $past(mem_req && mem_burst && mem_we)) |-> $past(mem_ack));

   // R7
   victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_start |-> !lock_mask[victim]);

   // R8
   bypass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && mem_req) |-> (mem_ack && !mem_burst));

   // R9
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> req_valid);
endmodule

bind lockable_dcache dc_checker #(.WAYS(WAYS), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .mpu_enable(mpu_enable),
   .lock_mask(lock_mask), .req_valid(req_valid), .req_ready(req_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
   .mem_ack(mem_ack), .miss_start(miss_start), .victim(victim)
);

// File: tb/lockable_dcache_test.sv
`timescale 1ns/1ps
module lockable_dcache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        mpu_enable = 1'b0;
   logic [3:0]  lock_mask = 4'h0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        req_ready;
   logic [31:0] rsp_rdata;
   logic        mem_req, mem_we, mem_burst, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;

   lockable_dcache uut (.*);

   always #2 clk = ~clk;

   logic [31:0] bmem   [4096];
   logic [31:0] shadow [4096];
   logic [31:0] log_addr [256];
   bit          log_we   [256];
   bit          log_burst[256];
   int          ev_n = 0;
   bit          init_done = 1'b0;
   logic        ack_phase = 1'b0;
   int          errors = 0;
   int          checks = 0;

   assign mem_ack   = mem_req && ack_phase;
   assign mem_rdata = bmem[mem_addr[13:2]];

   always @(posedge clk) ack_phase <= ($urandom_range(3) != 0);

   always @(negedge clk) begin
      if (!init_done) begin
         for (int i = 0; i < 4096; i++) bmem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
         init_done = 1'b1;
      end
      if (rst_n && mem_req && mem_ack) begin
         log_addr[ev_n % 256]  = mem_addr;
         log_we[ev_n % 256]    = mem_we;
         log_burst[ev_n % 256] = mem_burst;
         ev_n++;
         if (mem_we)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) bmem[mem_addr[13:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
      end
   end

   function automatic logic [31:0] la(input int tag, input int set, input int word);
      return 32'(tag * 1024 + set * 32 + word * 4);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; lock_mask = 4'h0;
      cfg_enable = 1'b1; mpu_enable = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4096; i++) shadow[i] = bmem[i];
      rst_n = 1'b1;
   endtask

   task automatic acc(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                      input logic [3:0] be, output logic [31:0] rd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
      forever begin
         #1;
         if (req_ready) break;
         @(negedge clk);
      end
      rd = rsp_rdata;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      if (wr)
         for (int b = 0; b < 4; b++)
            if (be[b]) shadow[a[13:2]][b*8 +: 8] = wd[b*8 +: 8];
   endtask

   task automatic rd_chk(input logic [31:0] a, input string req);
      logic [31:0] rd;
      acc(1'b0, a, '0, 4'h0, rd);
      chk(rd == shadow[a[13:2]], req, rd, shadow[a[13:2]]);
   endtask

   task automatic fill_set(input int set);
      for (int t = 0; t < 4; t++) rd_chk(la(t, set, 0), "R6 fill");
   endtask

   task automatic t_reset_state();
      int s;
      do_reset();
      #1;
      chk(req_ready == 1'b0, "R10 ready after reset", 32'(req_ready), 0);
      chk(mem_req == 1'b0, "R10 mem_req after reset", 32'(mem_req), 0);
      s = ev_n; rd_chk(la(1, 4, 3), "R10 first read");
      chk(ev_n - s == 8, "R10 first read fills", ev_n - s, 8);
      s = ev_n; rd_chk(la(1, 4, 3), "R10 second read");
      chk(ev_n - s == 0, "R10 second read hits", ev_n - s, 0);
      do_reset();
      s = ev_n; rd_chk(la(1, 4, 3), "R10 read after reset");
      chk(ev_n - s == 8, "R10 valid cleared by reset", ev_n - s, 8);
   endtask

   task automatic t_disabled();
      int s; logic [31:0] rd;
      do_reset();
      mpu_enable = 1'b0;
      s = ev_n; rd_chk(la(2, 1, 5), "R1 read protection off");
      chk(ev_n - s == 1, "R1 one beat", ev_n - s, 1);
      chk(log_burst[s % 256] == 1'b0, "R1 single transfer", 32'(log_burst[s % 256]), 0);
      s = ev_n; acc(1'b1, la(2, 1, 5), 32'hA1B2C3D4, 4'b0101, rd);
      chk(ev_n - s == 1 && log_we[s % 256], "R1 write goes out", ev_n - s, 1);
      chk(bmem[la(2, 1, 5) >> 2] == shadow[la(2, 1, 5) >> 2], "R1 byte enables",
          bmem[la(2, 1, 5) >> 2], shadow[la(2, 1, 5) >> 2]);
      cfg_enable = 1'b0; mpu_enable = 1'b1;
      s = ev_n; rd_chk(la(2, 1, 5), "R1 read cache off");
      chk(ev_n - s == 1, "R1 enable low single beat", ev_n - s, 1);
      cfg_enable = 1'b1;
      s = ev_n; rd_chk(la(2, 1, 5), "R1 read enabled");
      chk(ev_n - s == 8, "R1 enabled fills line", ev_n - s, 8);
   endtask

   task automatic t_refill();
      int s; bit ok;
      do_reset();
      s = ev_n; rd_chk(la(3, 6, 5), "R3 miss data");
      chk(ev_n - s == 8, "R3 burst length", ev_n - s, 8);
      ok = 1'b1;
      for (int k = 0; k < 8; k++)
         if (log_addr[(s + k) % 256] != la(3, 6, k) || log_we[(s + k) % 256] || !log_burst[(s + k) % 256])
            ok = 1'b0;
      chk(ok, "R3 beat order", log_addr[s % 256], la(3, 6, 0));
      s = ev_n;
      for (int k = 0; k < 8; k++) rd_chk(la(3, 6, k), "R2 line words");
      chk(ev_n - s == 0, "R2 line hits", ev_n - s, 0);
   endtask

   task automatic t_write_hit();
      int s; logic [31:0] rd; logic [31:0] old;
      do_reset();
      rd_chk(la(3, 6, 2), "R4 prefill");
      old = bmem[la(3, 6, 2) >> 2];
      s = ev_n; acc(1'b1, la(3, 6, 2), 32'h11223344, 4'b1001, rd);
      chk(ev_n - s == 0, "R4 write hit no traffic", ev_n - s, 0);
      chk(bmem[la(3, 6, 2) >> 2] == old, "R4 memory untouched", bmem[la(3, 6, 2) >> 2], old);
      rd_chk(la(3, 6, 2), "R4 merged bytes");
   endtask

   task automatic t_evict();
      int s; logic [31:0] rd; bit ok;
      do_reset();
      fill_set(2);
      acc(1'b1, la(0, 2, 1), 32'hCAFEF00D, 4'hF, rd);
      s = ev_n; rd_chk(la(4, 2, 0), "R5 miss data");
      chk(ev_n - s == 16, "R5 writeback plus refill", ev_n - s, 16);
      ok = 1'b1;
      for (int k = 0; k < 8; k++) begin
         if (log_addr[(s + k) % 256] != la(0, 2, k) || !log_we[(s + k) % 256]) ok = 1'b0;
         if (log_addr[(s + 8 + k) % 256] != la(4, 2, k) || log_we[(s + 8 + k) % 256]) ok = 1'b0;
      end
      chk(ok, "R5 writeback before refill", log_addr[s % 256], la(0, 2, 0));
      chk(bmem[la(0, 2, 1) >> 2] == 32'hCAFEF00D, "R5 memory updated",
          bmem[la(0, 2, 1) >> 2], 32'hCAFEF00D);
   endtask

   task automatic t_round_robin();
      int s;
      do_reset();
      fill_set(5);
      rd_chk(la(4, 5, 0), "R6 evict way 0");
      rd_chk(la(5, 5, 0), "R6 evict way 1");
      s = ev_n;
      rd_chk(la(2, 5, 0), "R6 tag2"); rd_chk(la(3, 5, 0), "R6 tag3");
      rd_chk(la(4, 5, 0), "R6 tag4"); rd_chk(la(5, 5, 0), "R6 tag5");
      chk(ev_n - s == 0, "R6 survivors hit", ev_n - s, 0);
      s = ev_n; rd_chk(la(0, 5, 0), "R6 tag0 again");
      chk(ev_n - s == 8, "R6 tag0 was evicted", ev_n - s, 8);
      s = ev_n; rd_chk(la(3, 5, 0), "R6 tag3 kept");
      chk(ev_n - s == 0, "R6 pointer skipped way 3", ev_n - s, 0);
      s = ev_n; rd_chk(la(2, 5, 0), "R6 tag2 gone");
      chk(ev_n - s == 8, "R6 way 2 replaced", ev_n - s, 8);
   endtask

   task automatic t_lock();
      int s; logic [31:0] rd;
      do_reset();
      fill_set(7);
      lock_mask = 4'b0011;
      for (int n = 0; n < 60; n++) begin
         int t = 4 + $urandom_range(7);
         int w = $urandom_range(7);
         if ($urandom_range(1) == 1) acc(1'b1, la(t, 7, w), $urandom, 4'hF, rd);
         else rd_chk(la(t, 7, w), "R7 conflict traffic");
      end
      s = ev_n;
      rd_chk(la(0, 7, 0), "R7 locked line 0"); rd_chk(la(1, 7, 0), "R7 locked line 1");
      chk(ev_n - s == 0, "R7 locked ways kept", ev_n - s, 0);
      s = ev_n; acc(1'b1, la(0, 7, 2), 32'h0BADBEEF, 4'hF, rd);
      rd_chk(la(0, 7, 2), "R9 locked write hit");
      chk(ev_n - s == 0, "R9 locked write served in cache", ev_n - s, 0);
   endtask

   task automatic t_all_locked();
      int s; logic [31:0] rd;
      do_reset();
      fill_set(9);
      lock_mask = 4'hF;
      s = ev_n; acc(1'b1, la(0, 9, 3), 32'h55AA33CC, 4'hF, rd);
      chk(ev_n - s == 0, "R9 write hit all locked", ev_n - s, 0);
      s = ev_n; rd_chk(la(6, 9, 0), "R8 bypass read");
      chk(ev_n - s == 1 && !log_burst[s % 256], "R8 single beat", ev_n - s, 1);
      s = ev_n; rd_chk(la(6, 9, 0), "R8 repeat read");
      chk(ev_n - s == 1, "R8 no allocation", ev_n - s, 1);
      s = ev_n; acc(1'b1, la(6, 9, 1), 32'h76543210, 4'hF, rd);
      chk(bmem[la(6, 9, 1) >> 2] == 32'h76543210, "R8 bypass write", bmem[la(6, 9, 1) >> 2], 32'h76543210);
      s = ev_n; rd_chk(la(0, 9, 3), "R9 locked read hit");
      chk(ev_n - s == 0, "R9 hit without traffic", ev_n - s, 0);
   endtask

   task automatic t_random();
      logic [31:0] rd; int bad0;
      do_reset();
      bad0 = errors;
      for (int n = 0; n < 300; n++) begin
         logic [31:0] a = la($urandom_range(7), $urandom_range(3), $urandom_range(7));
         if ($urandom_range(2) == 0) acc(1'b1, a, $urandom, 4'($urandom_range(15)), rd);
         else rd_chk(a, "R2 R4 R5 random traffic");
      end
      chk(errors == bad0, "R5 random traffic consistent", errors - bad0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_disabled();
      t_refill();
      t_write_hit();
      t_evict();
      t_round_robin();
      t_lock();
      t_all_locked();
      t_random();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule